// File: doc/BRIEF.md
# Break-Even Sleep Depth Controller

This block decides when a device with one active mode and several low-power modes may sleep, and how deeply. While the device is active it counts consecutive cycles in which nothing is requested and the device is not busy. Once that observation window is full it compares the idle time still expected against the break-even time of each low-power mode. The expected idle time is a predicted idle length plus any extra slack, for example from a task that finished early. It then picks the deepest mode whose break-even time fits. If no mode fits, the device stays active.

While asleep the selected mode is held until a request arrives. The request starts a wake sequence at the next clock edge. That sequence lasts exactly the wake latency of the mode being left, and only then does the ready flag rise. Break-even times and wake latencies are precomputed constants given as parameters. Mode 0 is the active mode, and modes 1 to NUM_MODES are progressively deeper. Both parameter tables are ordered so that higher indices are deeper.

`req` behaves like the valid half of a valid/ready pair, with `ready` as the other half. A request is served only in a cycle where both are high. A requester that sees `ready` low must keep `req` high, or raise it again later. A wake sequence, once started, always runs to completion, even if `req` drops.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset `mode_sel` is 0, `ready` is 1 and `waking` is 0, and the idle counter is cleared. The earliest possible sleep entry is at the (OBS_CYC+1)-th rising edge after reset is released with the inputs idle.
- R2: `mode_sel` encodes 0 as active and 1..NUM_MODES as low-power modes of increasing depth. `mode_sel` is 0 whenever `ready` or `waking` is 1, and `ready` and `waking` are never 1 together.
- R3: A cycle is idle when `req`=0 and `busy`=0. Sleep entry is decided at the edge that follows OBS_CYC consecutive idle cycles, provided that the current cycle is also idle. Any cycle with `req` or `busy` high restarts the count from zero.
- R4: At the decision, the mode chosen is the highest index m for which BREAK_EVEN[m] is less than or equal to the available idle time. The comparison is inclusive.
- R5: If no mode's break-even time is less than or equal to the available idle time, the block stays active with `ready`=1. The decision is repeated in every later idle cycle.
- R6: The available idle time is `idle_pred + slack`, saturated at 2^CNT_W-1.
- R7: While asleep, `mode_sel` holds its value until `req` is sampled high. That edge moves the block into the wake sequence, with `waking`=1 and `ready`=0.
- R8: The wake sequence keeps `waking` at 1 for exactly WAKE_LAT[m] cycles, where m is the mode being left, and then sets `ready` to 1. Dropping `req` during the sequence neither cancels it nor shortens it.
- R9: A `req` raised while the block is active, with `ready`=1, does not cause a wake sequence and keeps the block active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Service request, held until accepted with ready |
| busy | input | 1 | Device is still working; blocks idle counting |
| idle_pred | input | CNT_W | Predicted idle length in cycles |
| slack | input | CNT_W | Extra idle cycles from early completion |
| mode_sel | output | MODE_W | 0 active, 1..NUM_MODES deeper sleep |
| ready | output | 1 | Device in active mode and able to serve |
| waking | output | 1 | Wake transition in progress |

## Verification
Sleep entry is tried with predictions that fit no mode, that fit each mode exactly at its break-even value, and that fall one cycle short of it. Together these cases separate an inclusive comparison from an exclusive one and a deepest-fit choice from a first-fit choice. A prediction that fits only once slack is added shows that slack takes part in the choice, and maximal inputs show that the sum saturates instead of wrapping. Wake-ups from a shallow mode and from the deepest mode, with `req` held throughout and with `req` pulsed for one cycle, tell a per-mode latency apart from a fixed one and show that a dropped request does not cancel a wake. An idle run broken by `busy` just before the decision separates a count that restarts from one that merely pauses.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_SLEEP  = 2'd1,
    ST_WAKE   = 2'd2
  } pmc_state_e;

endpackage

// File: rtl/pmc_idle_window.sv
module pmc_idle_window #(
  parameter int OBS_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic full
);
  localparam int CW = $clog2(OBS_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(OBS_CYC);

  logic [CW-1:0] cnt;

  // Counts consecutive idle cycles, saturating at the window length.
  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign full = (cnt == LIMIT);
endmodule

// File: rtl/pmc_depth_select.sv
module pmc_depth_select #(
  parameter int NUM_MODES = 3,
  parameter int CNT_W     = 16,
  parameter logic [NUM_MODES*CNT_W-1:0] BREAK_EVEN = '0,
  localparam int MODE_W   = $clog2(NUM_MODES + 1)
) (
  input  logic [CNT_W-1:0]  idle_pred,
  input  logic [CNT_W-1:0]  slack,
  output logic [MODE_W-1:0] best
);
  logic [CNT_W:0]       sum;
  logic [CNT_W-1:0]     avail;
  logic [NUM_MODES-1:0] fits;

  // Saturating sum of the predicted idle time and the extra slack.
  assign sum   = {1'b0, idle_pred} + {1'b0, slack};
  assign avail = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_fit
    assign fits[g] = (BREAK_EVEN[g*CNT_W +: CNT_W] <= avail);
  end

  // Deepest fitting mode wins; later indices overwrite earlier ones.
  always_comb begin
    best = '0;
    for (int m = 0; m < NUM_MODES; m++) begin
      if (fits[m]) best = MODE_W'(m + 1);
    end
  end
endmodule

// File: rtl/pmc_wake_timer.sv
module pmc_wake_timer #(
  parameter int NUM_MODES = 3,
  parameter int WAKE_W    = 8,
  parameter logic [NUM_MODES*WAKE_W-1:0] WAKE_LAT = '0,
  localparam int MODE_W   = $clog2(NUM_MODES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [MODE_W-1:0] mode,
  output logic              done
);
  logic [WAKE_W-1:0] lat;
  logic [WAKE_W-1:0] cnt;

  always_comb begin
    lat = WAKE_W'(1);
    for (int m = 0; m < NUM_MODES; m++) begin
      if (mode == MODE_W'(m + 1)) lat = WAKE_LAT[m*WAKE_W +: WAKE_W];
    end
  end

  // Loaded with latency-1 as the wake starts; done when it reaches zero.
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load) cnt <= lat - 1'b1;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int NUM_MODES = 3,
  parameter int CNT_W     = 16,
  parameter int WAKE_W    = 8,
  parameter int OBS_CYC   = 4,
  parameter logic [NUM_MODES*CNT_W-1:0]  BREAK_EVEN = {16'd150, 16'd60, 16'd20},
  parameter logic [NUM_MODES*WAKE_W-1:0] WAKE_LAT   = {8'd12, 8'd5, 8'd2},
  localparam int MODE_W = $clog2(NUM_MODES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              busy,
  input  logic [CNT_W-1:0]  idle_pred,
  input  logic [CNT_W-1:0]  slack,
  output logic [MODE_W-1:0] mode_sel,
  output logic              ready,
  output logic              waking
);
  pmc_state_e        state;
  logic [MODE_W-1:0] mode_q;
  logic [MODE_W-1:0] best;
  logic              idle_now;
  logic              win_full;
  logic              wake_load;
  logic              wake_done;

  assign idle_now  = !req && !busy;
  assign wake_load = (state == ST_SLEEP) && req;

  pmc_idle_window #(.OBS_CYC(OBS_CYC)) u_win (
    .clk     (clk),
    .rst     (rst),
    .restart (!idle_now || (state != ST_ACTIVE)),
    .full    (win_full)
  );

  pmc_depth_select #(
    .NUM_MODES (NUM_MODES),
    .CNT_W     (CNT_W),
    .BREAK_EVEN(BREAK_EVEN)
  ) u_sel (
    .idle_pred (idle_pred),
    .slack     (slack),
    .best      (best)
  );

  pmc_wake_timer #(
    .NUM_MODES (NUM_MODES),
    .WAKE_W    (WAKE_W),
    .WAKE_LAT  (WAKE_LAT)
  ) u_wake (
    .clk  (clk),
    .rst  (rst),
    .load (wake_load),
    .mode (mode_q),
    .done (wake_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_ACTIVE;
      mode_q <= '0;
    end else begin
      unique case (state)
        ST_ACTIVE: if (idle_now && win_full && best != '0) begin
          state  <= ST_SLEEP;
          mode_q <= best;
        end
        ST_SLEEP:  if (req) state <= ST_WAKE;
        ST_WAKE:   if (wake_done) begin
          state  <= ST_ACTIVE;
          mode_q <= '0;
        end
        default:   state <= ST_ACTIVE;
      endcase
    end
  end

  assign mode_sel = (state == ST_SLEEP) ? mode_q : '0;
  assign ready    = (state == ST_ACTIVE);
  assign waking   = (state == ST_WAKE);
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
  parameter int NUM_MODES = 3,
  parameter int WAKE_W    = 8,
  parameter logic [NUM_MODES*WAKE_W-1:0] WAKE_LAT = '0,
  localparam int MODE_W   = $clog2(NUM_MODES + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic [MODE_W-1:0] mode_sel,
  input logic              ready,
  input logic              waking
);
  logic [MODE_W-1:0] last_sleep;
  logic [WAKE_W:0]   run;
  logic [WAKE_W:0]   exp_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_sleep <= '0;
      run        <= '0;
    end else begin
      if (mode_sel != '0) last_sleep <= mode_sel;
      run <= waking ? run + 1'b1 : '0;
    end
  end

  always_comb begin
    exp_run = '0;
    for (int m = 0; m < NUM_MODES; m++) begin
      if (last_sleep == MODE_W'(m + 1)) exp_run = {1'b0, WAKE_LAT[m*WAKE_W +: WAKE_W]};
    end
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (mode_sel == '0 && ready && !waking));

  a_r2_active_mode: assert property (@(posedge clk) disable iff (rst)
    (ready || waking) |-> (mode_sel == '0));

  a_r2_excl: assert property (@(posedge clk) disable iff (rst)
    !(ready && waking));

  a_r7_hold_sleep: assert property (@(posedge clk) disable iff (rst)
    (mode_sel != '0 && !req) |=> (mode_sel == $past(mode_sel)));

  a_r7_wake_start: assert property (@(posedge clk) disable iff (rst)
    (mode_sel != '0 && req) |=> (waking && !ready));

  a_r8_wake_length: assert property (@(posedge clk) disable iff (rst)
    $fell(waking) |-> (run == exp_run && ready));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(
  .NUM_MODES(NUM_MODES),
  .WAKE_W   (WAKE_W),
  .WAKE_LAT (WAKE_LAT)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .req     (req),
  .mode_sel(mode_sel),
  .ready   (ready),
  .waking  (waking)
);

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/100ps
module pwr_mode_ctrl_tb;
  localparam int OBS = 4;
  localparam int W1 = 2, W2 = 5, W3 = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        busy = 1'b0;
  logic [15:0] idle_pred = '0;
  logic [15:0] slack = '0;
  logic [1:0]  mode_sel;
  logic        ready;
  logic        waking;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl u_dut (
    .clk(clk), .rst(rst), .req(req), .busy(busy),
    .idle_pred(idle_pred), .slack(slack),
    .mode_sel(mode_sel), .ready(ready), .waking(waking)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Clears the idle window, then idles with the given prediction.
  task automatic try_sleep(input int pred, input int slk, input int exp, input string tag);
    busy = 1'b1; req = 1'b0;
    tick(1);
    busy = 1'b0; idle_pred = 16'(pred); slack = 16'(slk);
    tick(OBS);
    chk({tag, " R3 still active before decision"}, mode_sel, 0);
    tick(1);
    chk({tag, " R4 chosen mode"}, mode_sel, exp);
    if (exp == 0) begin
      tick(20);
      chk({tag, " R5 stays active"}, {mode_sel, ready}, 1);
    end
  endtask

  task automatic wake(input int lat, input bit pulse, input string tag);
    req = 1'b1;
    tick(1);
    chk({tag, " R7 wake starts"}, {waking, ready, mode_sel}, 8);
    if (pulse) req = 1'b0;
    tick(lat - 1);
    chk({tag, " R8 still waking"}, {waking, ready}, 2);
    tick(1);
    chk({tag, " R8 ready after latency"}, {waking, ready}, 1);
    req = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 reset mode", mode_sel, 0);
    chk("R1 reset ready", ready, 1);
    chk("R1 reset waking", waking, 0);
  endtask

  task automatic t_busy_restart;
    busy = 1'b1;
    tick(1);
    busy = 1'b0; idle_pred = 16'd30; slack = '0;
    tick(3);
    busy = 1'b1;
    tick(1);
    busy = 1'b0;
    tick(OBS);
    chk("R3 busy restarted count", mode_sel, 0);
    tick(1);
    chk("R3 sleeps after full window", mode_sel, 1);
    wake(W1, 1'b0, "R3 exit");
  endtask

  task automatic t_req_active;
    req = 1'b1;
    tick(3);
    chk("R9 req while ready", {mode_sel, waking, ready}, 1);
    req = 1'b0;
  endtask

  task automatic t_hold;
    try_sleep(200, 0, 3, "R7 hold");
    tick(30);
    chk("R7 mode held while asleep", {mode_sel, ready}, 6);
    wake(W3, 1'b1, "R8 pulsed req deep");
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    t_reset();
    // Inputs idle since reset: decision at edge OBS+1.
    idle_pred = 16'd30;
    tick(OBS);
    chk("R1 counter cleared at reset", mode_sel, 0);
    tick(1);
    chk("R1 first sleep", mode_sel, 1);
    wake(W1, 1'b0, "R8 mode1");

    try_sleep(10, 0, 0, "R5 nothing fits");
    try_sleep(19, 0, 0, "R4 below first");
    try_sleep(20, 0, 1, "R4 exact first");
    wake(W1, 1'b1, "R8 pulsed shallow");
    try_sleep(59, 0, 1, "R4 one short");
    wake(W1, 1'b0, "R8 m1");
    try_sleep(60, 0, 2, "R4 exact second");
    wake(W2, 1'b0, "R8 m2");
    try_sleep(149, 0, 2, "R4 below deepest");
    wake(W2, 1'b0, "R8 m2b");
    try_sleep(150, 0, 3, "R4 exact deepest");
    wake(W3, 1'b0, "R8 m3");
    try_sleep(40, 30, 2, "R6 slack adds");
    wake(W2, 1'b0, "R6 exit");
    try_sleep(65535, 65535, 3, "R6 saturation");
    wake(W3, 1'b0, "R6 sat exit");
    try_sleep(65535, 1, 3, "R6 carry saturates");
    wake(W3, 1'b0, "R6 carry exit");
    t_busy_restart();
    t_req_active();
    t_hold();
    chk("R2 ready implies active", {ready, mode_sel}, 4);
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule